// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block sits on the master side of a processor bus where the address and data share one set of lines. The core hands it a single request: read or write, memory or I/O space, an address and, for writes, a data word. The block then runs a fixed sequence of clock states and answers the core with a one-clock completion pulse and, for reads, the captured data word.

A transfer with no wait states takes exactly four clocks, T1 to T4. That gives 800 ns per transfer at a 5 MHz clock. The sequence is as follows:

- T1 places the address on the shared lines and raises the address strobe.
- T2 asserts the read or write strobe and the transceiver enable. On a write, the data word replaces the address on the shared lines.
- The target can stretch the transfer by holding `bus_ready` low. Each low sample adds one wait state TW before T3.
- Read data is captured at the end of T3.
- T4 drops every strobe.

A new request is taken when the block is idle, or during T4, which gives back-to-back transfers with no idle clock between them.

The states are S_IDLE, S_T1, S_T2, S_TW, S_T3 and S_T4. The transitions are:

- S_IDLE→S_T1 on accept
- S_T1→S_T2 always
- S_T2→S_T3 when ready
- S_T2→S_TW when not ready
- S_TW→S_TW when not ready
- S_TW→S_T3 when ready
- S_T3→S_T4 always
- S_T4→S_T1 on accept
- S_T4→S_IDLE otherwise

Top module: `mux_bus_seq`

## Requirements
- R1: A synchronous reset, applied in any state, returns the block to idle. On the clock after reset: `busy`=0, `done`=0, `addr_stb`=0, `xcvr_en`=0, `rd_stb_n`=1, `wr_stb_n`=1, `ad_oe`=0.
- R2: `req_valid` is accepted only while idle or in T4, and acceptance makes the next clock T1. A request that is raised and dropped again between T1 and T3 has no effect, and the block returns to idle after T4.
- R3: `addr_stb` is 1 only in T1. In T1, `ad_out` carries the latched request address with `ad_oe`=1. `dir_out` is 1 for a write and 0 for a read from T1 through T4.
- R4: From T2 through T3, including wait states, the block drives `rd_stb_n`=0 on a read or `wr_stb_n`=0 on a write, and drives `xcvr_en`=1. All three are inactive in T4 and in idle, and the two strobes are never low together.
- R5: `bus_ready` is sampled at the end of T2 and at the end of every TW. Each low sample inserts one TW, so a transfer with n low samples lasts 4+n clocks, T1 to T4 inclusive.
- R6: On a read, `ad_oe` is 0 from T2 through T4.
- R7: On a write, `ad_oe` is 1 from T1 through T4, and `ad_out` carries the write data, zero-extended to AW bits, from T2 through T4.
- R8: On a read, `rd_data` takes `ad_in[DW-1:0]` as sampled at the end of T3. It is valid during T4 and holds until the next read completes. A write leaves it unchanged.
- R9: `busy` is 1 from T1 through T4. `done` is 1 during T4 only, for exactly one clock per transfer.
- R10: With MIO_MEM_HIGH=0, `mem_io` is 1 for an I/O access and 0 for a memory access. With MIO_MEM_HIGH=1 the sense is reversed. The value follows the latched request from T1 through T4.
- R11: A request presented during T4 is accepted at the end of T4, and the next clock is T1 of the new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Transfer in progress (T1..T4) |
| done | output | 1 | One-clock completion pulse in T4 |
| rd_data | output | DW | Captured read data |
| bus_ready | input | 1 | Target ready; low inserts wait states |
| ad_in | input | AW | Shared lines as seen from the pins |
| ad_out | output | AW | Value driven onto the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| addr_stb | output | 1 | Address latch strobe, high in T1 |
| dir_out | output | 1 | Transceiver direction, 1 = outbound |
| xcvr_en | output | 1 | Transceiver enable |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |
| mem_io | output | 1 | Memory / I/O space indicator |

## Verification
A wrong state register shows at the pins on the very next clock. Examples are a missed TW, an early T3 or a skipped T4: a strobe, `xcvr_en` or `done` then appears one cycle off the 4+n count, so every pin is compared on every clock of every transfer. A capture taken in the wrong state returns the complement of the expected word, because the bench's target drives the correct word only during T3. A request latch that follows the live inputs is caught from T2 onward, because the bench scrambles those inputs once the request has been accepted.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_T1   = 3'd1,
        S_T2   = 3'd2,
        S_TW   = 3'd3,
        S_T3   = 3'd4,
        S_T4   = 3'd5
    } bus_state_t;
endpackage

// File: rtl/mbs_seq.sv
module mbs_seq
    import mbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       bus_ready,
    output bus_state_t state,
    output logic       accept
);
    bus_state_t nxt;

    // A request is taken only when the bus is free or about to be.
    assign accept = req_valid && (state == S_IDLE || state == S_T4);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  nxt = accept ? S_T1 : S_IDLE;
            S_T1:    nxt = S_T2;
            S_T2:    nxt = bus_ready ? S_T3 : S_TW;
            S_TW:    nxt = bus_ready ? S_T3 : S_TW;
            S_T3:    nxt = S_T4;
            S_T4:    nxt = accept ? S_T1 : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/mbs_req_reg.sv
module mbs_req_reg
    import mbs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  bus_state_t    state,
    input  logic          req_write,
    input  logic          req_io,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [AW-1:0] ad_in,
    output logic          q_write,
    output logic          q_io,
    output logic [AW-1:0] q_addr,
    output logic [DW-1:0] q_wdata,
    output logic [DW-1:0] q_rdata
);
    logic cap_en;

    // Read data is taken on the edge that leaves T3.
    assign cap_en = (state == S_T3) && !q_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_write <= 1'b0;
            q_io    <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
        end else if (accept) begin
            q_write <= req_write;
            q_io    <= req_io;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         q_rdata <= '0;
        else if (cap_en) q_rdata <= ad_in[DW-1:0];
    end
endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
    import mbs_pkg::*;
#(
    parameter int AW           = 16,
    parameter int DW           = 16,
    parameter bit MIO_MEM_HIGH = 1'b0
) (
    input  bus_state_t    state,
    input  logic          q_write,
    input  logic          q_io,
    input  logic [AW-1:0] q_addr,
    input  logic [DW-1:0] q_wdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ad_out,
    output logic          ad_oe,
    output logic          addr_stb,
    output logic          dir_out,
    output logic          xcvr_en,
    output logic          rd_stb_n,
    output logic          wr_stb_n,
    output logic          mem_io
);
    logic [AW-1:0] wext;

    always_comb begin
        wext           = '0;
        wext[DW-1:0]   = q_wdata;
    end

    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        ad_out   = '0;
        ad_oe    = 1'b0;
        addr_stb = 1'b0;
        dir_out  = 1'b0;
        xcvr_en  = 1'b0;
        rd_stb_n = 1'b1;
        wr_stb_n = 1'b1;
        mem_io   = q_io ^ MIO_MEM_HIGH;
        unique case (state)
            S_IDLE: begin
            end
            S_T1: begin
                busy     = 1'b1;
                addr_stb = 1'b1;
                dir_out  = q_write;
                ad_oe    = 1'b1;
                ad_out   = q_addr;
            end
            S_T2, S_TW, S_T3: begin
                busy     = 1'b1;
                dir_out  = q_write;
                xcvr_en  = 1'b1;
                rd_stb_n = q_write;
                wr_stb_n = !q_write;
                ad_oe    = q_write;
                ad_out   = q_write ? wext : '0;
            end
            S_T4: begin
                busy     = 1'b1;
                done     = 1'b1;
                dir_out  = q_write;
                ad_oe    = q_write;
                ad_out   = q_write ? wext : '0;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int AW           = 16,
    parameter int DW           = 16,
    parameter bit MIO_MEM_HIGH = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_io,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    input  logic          bus_ready,
    input  logic [AW-1:0] ad_in,
    output logic [AW-1:0] ad_out,
    output logic          ad_oe,
    output logic          addr_stb,
    output logic          dir_out,
    output logic          xcvr_en,
    output logic          rd_stb_n,
    output logic          wr_stb_n,
    output logic          mem_io
);
    bus_state_t    state;
    logic          accept;
    logic          q_write;
    logic          q_io;
    logic [AW-1:0] q_addr;
    logic [DW-1:0] q_wdata;

    mbs_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .state     (state),
        .accept    (accept)
    );

    mbs_req_reg #(.AW(AW), .DW(DW)) u_req (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .state     (state),
        .req_write (req_write),
        .req_io    (req_io),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ad_in     (ad_in),
        .q_write   (q_write),
        .q_io      (q_io),
        .q_addr    (q_addr),
        .q_wdata   (q_wdata),
        .q_rdata   (rd_data)
    );

    mbs_pins #(.AW(AW), .DW(DW), .MIO_MEM_HIGH(MIO_MEM_HIGH)) u_pins (
        .state    (state),
        .q_write  (q_write),
        .q_io     (q_io),
        .q_addr   (q_addr),
        .q_wdata  (q_wdata),
        .busy     (busy),
        .done     (done),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .addr_stb (addr_stb),
        .dir_out  (dir_out),
        .xcvr_en  (xcvr_en),
        .rd_stb_n (rd_stb_n),
        .wr_stb_n (wr_stb_n),
        .mem_io   (mem_io)
    );
endmodule

// File: rtl/mbs_chk.sv
module mbs_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic bus_ready,
    input logic busy,
    input logic done,
    input logic ad_oe,
    input logic addr_stb,
    input logic xcvr_en,
    input logic rd_stb_n,
    input logic wr_stb_n
);
    // R2: an idle request starts T1 on the next clock
    a_r2_idle_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (addr_stb && busy));

    // R3: no strobe or transceiver activity while the address is latched
    a_r3_addr_phase_quiet: assert property (@(posedge clk) disable iff (rst)
        addr_stb |-> (rd_stb_n && wr_stb_n && !xcvr_en && ad_oe));

    // R4: read and write strobes are mutually exclusive
    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rd_stb_n && !wr_stb_n));

    // R4: any active strobe comes with the transceiver enabled
    a_r4_xcvr_with_strobe: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb_n || !wr_stb_n) |-> xcvr_en);

    // R5: a low ready sample keeps the strobe active for another clock
    a_r5_wait_holds: assert property (@(posedge clk) disable iff (rst)
        ((!rd_stb_n || !wr_stb_n) && !bus_ready) |=> (!rd_stb_n || !wr_stb_n));

    // R6: the lines are released whenever the read strobe is active
    a_r6_read_release: assert property (@(posedge clk) disable iff (rst)
        !rd_stb_n |-> !ad_oe);

    // R9: done lasts one clock
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: without a new request, done is followed by idle
    a_r9_done_to_idle: assert property (@(posedge clk) disable iff (rst)
        (done && !req_valid) |=> !busy);
endmodule

bind mux_bus_seq mbs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .bus_ready (bus_ready),
    .busy      (busy),
    .done      (done),
    .ad_oe     (ad_oe),
    .addr_stb  (addr_stb),
    .xcvr_en   (xcvr_en),
    .rd_stb_n  (rd_stb_n),
    .wr_stb_n  (wr_stb_n)
);

// File: tb/sim_mux_bus_seq.sv
`timescale 1ns/1ps
module sim_mux_bus_seq;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_io = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          bus_ready = 1'b1;
    logic [AW-1:0] ad_in = '0;

    logic          busy, done, ad_oe, addr_stb, dir_out, xcvr_en, rd_stb_n, wr_stb_n, mem_io;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] ad_out;

    logic          busy1, done1, ad_oe1, addr_stb1, dir_out1, xcvr_en1, rd_stb_n1, wr_stb_n1, mem_io1;
    logic [DW-1:0] rd_data1;
    logic [AW-1:0] ad_out1;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    int            tgt_waits = 0;
    logic [DW-1:0] tgt_data = '0;
    int            strobe_cnt = 0;
    logic [DW-1:0] last_rd = '0;

    always #2 clk = ~clk;

    mux_bus_seq #(.AW(AW), .DW(DW), .MIO_MEM_HIGH(1'b0)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .bus_ready(bus_ready),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr_stb(addr_stb),
        .dir_out(dir_out), .xcvr_en(xcvr_en), .rd_stb_n(rd_stb_n),
        .wr_stb_n(wr_stb_n), .mem_io(mem_io)
    );

    mux_bus_seq #(.AW(AW), .DW(DW), .MIO_MEM_HIGH(1'b1)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy1), .done(done1), .rd_data(rd_data1), .bus_ready(bus_ready),
        .ad_in(ad_in), .ad_out(ad_out1), .ad_oe(ad_oe1), .addr_stb(addr_stb1),
        .dir_out(dir_out1), .xcvr_en(xcvr_en1), .rd_stb_n(rd_stb_n1),
        .wr_stb_n(wr_stb_n1), .mem_io(mem_io1)
    );

    // Target model: counts clocks of active strobe, holds ready low for
    // tgt_waits samples, and drives the right word only in the T3 clock.
    always @(negedge clk) begin
        if (!rd_stb_n || !wr_stb_n) begin
            strobe_cnt = strobe_cnt + 1;
            bus_ready  = (strobe_cnt > tgt_waits);
            ad_in      = (strobe_cnt == tgt_waits + 2) ? tgt_data : ~tgt_data;
        end else begin
            strobe_cnt = 0;
            bus_ready  = 1'b1;
            ad_in      = ~tgt_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " busy"}, busy, 0);
        chk({tag, " done"}, done, 0);
        chk({tag, " addr_stb"}, addr_stb, 0);
        chk({tag, " xcvr_en"}, xcvr_en, 0);
        chk({tag, " rd_stb_n"}, rd_stb_n, 1);
        chk({tag, " wr_stb_n"}, wr_stb_n, 1);
        chk({tag, " ad_oe"}, ad_oe, 0);
    endtask

    // Called at a negedge in idle or T4; returns at the negedge of T4.
    task automatic txn(input bit wr, input bit io, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input int n, input bit stray);
        logic [AW-1:0] wext;
        wext = '0;
        wext[DW-1:0] = d;
        req_valid = 1'b1; req_write = wr; req_io = io;
        req_addr = a; req_wdata = d;
        tgt_waits = n; tgt_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = ~wr; req_io = ~io;
        req_addr = ~a; req_wdata = ~d;
        if (!wr) last_rd = d;
        for (int i = 0; i < n + 4; i++) begin
            bit t1, t4, act;
            if (i > 0) @(negedge clk);
            if (stray && i == 1) req_valid = 1'b1;
            if (stray && i == 2) req_valid = 1'b0;
            t1  = (i == 0);
            t4  = (i == n + 3);
            act = (i >= 1) && (i <= n + 2);
            chk("R11/R3 addr_stb", addr_stb, t1);
            chk("R9 busy", busy, 1);
            chk("R9 done", done, t4);
            chk("R4/R5 xcvr_en", xcvr_en, act);
            chk("R4/R5 rd_stb_n", rd_stb_n, !(act && !wr));
            chk("R4/R5 wr_stb_n", wr_stb_n, !(act && wr));
            chk("R3 dir_out", dir_out, wr);
            chk("R6/R7 ad_oe", ad_oe, t1 || wr);
            if (t1)      chk("R3 ad_out addr", ad_out, a);
            else if (wr) chk("R7 ad_out data", ad_out, wext);
            chk("R10 mem_io mode0", mem_io, io);
            chk("R10 mem_io mode1", mem_io1, !io);
            if (t4) chk("R8 rd_data", rd_data, last_rd);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_idle("R1 reset");

        // Sweep: direction x space x wait count, idle between transfers.
        for (int n = 0; n < 4; n++)
            for (int wr = 0; wr < 2; wr++)
                for (int io = 0; io < 2; io++) begin
                    logic [AW-1:0] a;
                    logic [DW-1:0] d;
                    a = AW'(16'h1234 * (n + 1) + 16'h0101 * (wr * 2 + io));
                    d = DW'(16'hA5C3 ^ (16'h1111 * (n * 4 + wr * 2 + io)));
                    txn(wr[0], io[0], a, d, n, 1'b0);
                    @(negedge clk);
                    chk_idle("R9 after T4");
                end

        // Stray request pulse during T2 must not start a new transfer.
        txn(1'b0, 1'b0, 16'h0F0F, 16'h3C3C, 1, 1'b1);
        @(negedge clk);
        chk_idle("R2 stray ignored");

        // Back-to-back chain with mixed waits; next request given in T4.
        txn(1'b0, 1'b1, 16'h8001, 16'h5A5A, 0, 1'b0);
        txn(1'b1, 1'b0, 16'h8002, 16'hC0DE, 2, 1'b0);
        txn(1'b0, 1'b0, 16'h8003, 16'h7E81, 3, 1'b0);
        txn(1'b1, 1'b1, 16'h8004, 16'hFFFF, 0, 1'b0);
        @(negedge clk);
        chk_idle("R11 chain end");

        // Reset in the middle of a waited read.
        req_valid = 1'b1; req_write = 1'b0; req_io = 1'b0;
        req_addr = 16'h4444; tgt_waits = 3; tgt_data = 16'h1357;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_idle("R1 mid-cycle reset");
        chk("R1 rd_data cleared", rd_data, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule